// File: doc/BRIEF.md
# Per-Channel Threshold Zero Suppressor

The block sits at the readout end of a calorimeter front end. One digitised pad sample arrives per cycle. It comes with the channel it belongs to and the bunch-crossing number in which it was taken. Every channel is sampled once per crossing. For each sample the block looks up a per-channel baseline (pedestal) and a per-channel cut level (threshold), both held in on-chip RAM. It subtracts the baseline, clamping at zero, and keeps the sample only if the result lies above the cut.

Each kept sample is packed into a 32-bit word that carries the channel, the crossing and the corrected amplitude. The word goes into a FIFO, so bursts of hits leave through a valid/ready port at whatever rate the link takes them. When the FIFO is full, new hits are discarded and counted. A status read returns that count and clears it.

A control bit turns off the cut so that every sample is forwarded. With the baselines loaded as zero, this gives raw data for monitoring baseline and noise.

Top module: `zs_suppress`

## Requirements
- R1: After a synchronous reset, `out_valid`, `ovf_flag` and `drop_count` are zero and the forward-all mode is off.
- R2: A cycle with `cfg_we` high writes `cfg_data[13:0]` into the entry of channel `cfg_chan` selected by `cfg_kind`: 0 selects the baseline and 1 selects the cut level. When `cfg_kind` is 2, the cycle instead loads `cfg_data[0]` into the forward-all bit. A cfg_kind of 3 has no effect.
- R3: The corrected amplitude is `in_sample[13:0]` minus the channel baseline, or zero when the baseline is larger. Bits 15:14 of `in_sample` have no effect.
- R4: With forward-all off, a sample is kept only when its corrected amplitude is strictly greater than the channel cut level.
- R5: The amplitude field of the output word saturates at 4095.
- R6: An output word holds the channel in bits 31:25, the crossing number in bits 24:12 and the amplitude in bits 11:0.
- R7: With forward-all on, every sample presented with `in_valid` high produces an output word, whatever its amplitude.
- R8: Words leave in input order. A word moves on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R9: A kept sample that reaches a full FIFO is discarded. It sets the sticky `ovf_flag` and increments `drop_count`, which saturates at its maximum.
- R10: A cycle with `stat_rd` high clears `ovf_flag` and `drop_count` on the next clock edge.
- R11: Cycles with `in_valid` low produce no output, whatever the other input pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_chan | input | 7 | Channel of the sample |
| in_xing | input | 13 | Bunch-crossing number of the sample |
| in_sample | input | 16 | Sample container, ADC code in bits 13:0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 baseline, 1 cut level, 2 control |
| cfg_chan | input | 7 | Channel addressed by a table write |
| cfg_data | input | 16 | Value written |
| stat_rd | input | 1 | Status read; clears the overflow statistics |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 32 | Packed hit word |
| ovf_flag | output | 1 | Sticky overflow flag |
| drop_count | output | 16 | Count of discarded hits |

## Verification
The bench aims at the edges of the cut.

- A sample exactly at baseline plus cut level must be dropped and one count above must be kept. An off-by-one compare would pass or lose a hit at the boundary.
- A baseline above the sample must give an amplitude of zero. A design that wrapped the subtraction would report a huge amplitude.
- A full-scale sample on a zero baseline must read 4095. A design that truncated instead of saturating would show a small value.
- Junk in the two upper container bits must not change the result.

A stalled sink with more hits arriving than the FIFO holds must leave the first words intact and in order. The discard count must be exact, and it must clear after a status read. A design that overwrote the FIFO, or lost the flag or count, shows up as a wrong word or a wrong count.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    CFG_BASE = 2'd0,
    CFG_CUT  = 2'd1,
    CFG_CTRL = 2'd2,
    CFG_NONE = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/zs_cal_ram.sv
module zs_cal_ram #(
  parameter int AW = 7,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/zs_hit_fifo.sv
module zs_hit_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic         not_empty,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;
  logic          do_wr, do_rd;

  assign full      = (fill == (AW+1)'(DEPTH));
  assign not_empty = (fill != '0);
  assign do_wr     = wr_en && !full;
  assign do_rd     = rd_en && not_empty;
  assign rd_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/zs_suppress.sv
module zs_suppress
  import zs_pkg::*;
#(
  parameter int NCHAN      = 128,
  parameter int ADC_W      = 14,
  parameter int SAMP_W     = 16,
  parameter int XING_W     = 13,
  parameter int VAL_W      = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 16,
  localparam int CH_W      = $clog2(NCHAN),
  localparam int WORD_W    = CH_W + XING_W + VAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [XING_W-1:0] in_xing,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [15:0]       cfg_data,
  input  logic              stat_rd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              ovf_flag,
  output logic [DROP_W-1:0] drop_count
);
  cfg_kind_e kind;
  assign kind = cfg_kind_e'(cfg_kind);

  logic             fwd_all;
  logic [ADC_W-1:0] base_q, cut_q;

  always_ff @(posedge clk) begin
    if (rst) fwd_all <= 1'b0;
    else if (cfg_we && kind == CFG_CTRL) fwd_all <= cfg_data[0];
  end

  zs_cal_ram #(.AW(CH_W), .DW(ADC_W)) u_base (
    .clk(clk), .we(cfg_we && kind == CFG_BASE), .waddr(cfg_chan),
    .wdata(cfg_data[ADC_W-1:0]), .raddr(in_chan), .rdata(base_q));

  zs_cal_ram #(.AW(CH_W), .DW(ADC_W)) u_cut (
    .clk(clk), .we(cfg_we && kind == CFG_CUT), .waddr(cfg_chan),
    .wdata(cfg_data[ADC_W-1:0]), .raddr(in_chan), .rdata(cut_q));

  // stage 1: align sample fields with table read
  logic              s1_v;
  logic [CH_W-1:0]   s1_chan;
  logic [XING_W-1:0] s1_xing;
  logic [ADC_W-1:0]  s1_adc;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_chan <= in_chan;
    s1_xing <= in_xing;
    s1_adc  <= in_sample[ADC_W-1:0];
  end

  // stage 2: subtract, clamp, compare, saturate
  logic [ADC_W:0]   diff_raw;
  logic [ADC_W-1:0] amp;
  logic [VAL_W-1:0] amp_sat;
  logic             keep;

  always_comb begin
    diff_raw = {1'b0, s1_adc} - {1'b0, base_q};
    amp      = diff_raw[ADC_W] ? '0 : diff_raw[ADC_W-1:0];
    amp_sat  = (|amp[ADC_W-1:VAL_W]) ? '1 : amp[VAL_W-1:0];
    keep     = s1_v && (fwd_all || (amp > cut_q));
  end

  logic              s2_push;
  logic [WORD_W-1:0] s2_word;

  always_ff @(posedge clk) begin
    if (rst) s2_push <= 1'b0;
    else     s2_push <= keep;
    s2_word <= {s1_chan, s1_xing, amp_sat};
  end

  logic fifo_full, drop_evt;

  zs_hit_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(s2_push), .wr_data(s2_word),
    .full(fifo_full), .rd_en(out_ready), .not_empty(out_valid),
    .rd_data(out_data));

  assign drop_evt = s2_push && fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      drop_count <= '0;
    end else if (stat_rd) begin
      ovf_flag   <= drop_evt;
      drop_count <= drop_evt ? DROP_W'(1) : '0;
    end else if (drop_evt) begin
      ovf_flag <= 1'b1;
      if (drop_count != '1) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/zs_checker.sv
module zs_checker #(
  parameter int WORD_W = 32,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              stat_rd,
  input logic              drop_evt,
  input logic              ovf_flag,
  input logic [DROP_W-1:0] drop_count
);
  a_r1_empty_after_reset: assert property (@(posedge clk)
    rst |=> !out_valid && !ovf_flag && drop_count == '0);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !stat_rd |=> ovf_flag);

  a_r9_drop_sets_flag: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> ovf_flag);

  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    drop_evt && !stat_rd && drop_count != '1 |=> drop_count == $past(drop_count) + 1'b1);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !drop_evt |=> !ovf_flag && drop_count == '0);
endmodule

bind zs_suppress zs_checker #(.WORD_W(WORD_W), .DROP_W(DROP_W)) u_zs_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .stat_rd(stat_rd), .drop_evt(drop_evt),
  .ovf_flag(ovf_flag), .drop_count(drop_count));

// File: tb/zs_suppress_test.sv
module zs_suppress_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 0;
  logic [6:0]  in_chan = 0;
  logic [12:0] in_xing = 0;
  logic [15:0] in_sample = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_kind = 0;
  logic [6:0]  cfg_chan = 0;
  logic [15:0] cfg_data = 0;
  logic        stat_rd = 0;
  logic        out_ready = 0;
  logic        out_valid, ovf_flag;
  logic [31:0] out_data;
  logic [15:0] drop_count;

  zs_suppress #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_xing(in_xing), .in_sample(in_sample), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_chan(cfg_chan), .cfg_data(cfg_data),
    .stat_rd(stat_rd), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ovf_flag(ovf_flag), .drop_count(drop_count));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int base_m [128];
  int cut_m  [128];
  bit fwd_m = 0;
  logic [31:0] expq [$];
  int xing_ctr = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int amp_of(int ch, int s);
    int d = (s & 16383) - base_m[ch];
    return (d < 0) ? 0 : d;
  endfunction

  function automatic logic [31:0] word_of(int ch, int x, int s);
    int a = amp_of(ch, s);
    if (a > 4095) a = 4095;
    return {7'(ch), 13'(x), 12'(a)};
  endfunction

  // one cycle: drive at negedge, then watch the handshake of the coming edge
  task automatic step(string req = "R8");
    #1;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check(0, req, out_data, 32'h0);
      else begin
        logic [31:0] e = expq.pop_front();
        check(out_data == e, req, out_data, e);
      end
    end
    @(negedge clk);
  endtask

  task automatic cfg(int kind, int ch, int val);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_chan = 7'(ch); cfg_data = 16'(val);
    if (kind == 0) base_m[ch] = val & 16383;
    if (kind == 1) cut_m[ch]  = val & 16383;
    if (kind == 2) fwd_m      = val[0];
    step();
    cfg_we = 0;
  endtask

  // present one sample; the model decides whether it is expected
  task automatic sample(int ch, int s, bit room, string req);
    in_valid = 1; in_chan = 7'(ch); in_xing = 13'(xing_ctr); in_sample = 16'(s);
    if ((fwd_m || amp_of(ch, s) > cut_m[ch]) && room) expq.push_back(word_of(ch, xing_ctr, s));
    xing_ctr = (xing_ctr + 1) % 8192;
    step(req);
    in_valid = 0;
  endtask

  task automatic drain(string req);
    out_ready = 1;
    for (int i = 0; i < 200 && expq.size() != 0; i++) step(req);
    repeat (4) step(req);
    check(expq.size() == 0, req, 32'(expq.size()), 32'h0);
    check(!out_valid, req, {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    rst = 0;
    #1;
    check(!out_valid && !ovf_flag && drop_count == 0, "R1",
          {ovf_flag, out_valid, drop_count}, 32'h0);
    @(negedge clk);

    // R2: load every table entry
    for (int c = 0; c < 128; c++) begin
      cfg(0, c, 200 + ($urandom % 300));
      cfg(1, c, 5 + ($urandom % 60));
    end
    cfg(0, 5, 0);    cfg(1, 5, 10);
    cfg(0, 6, 9000); cfg(1, 6, 0);
    cfg(0, 7, 1000); cfg(1, 7, 50);
    cfg(3, 7, 16'hFFFF); // R2: unused kind leaves chan 7 alone
    out_ready = 1;

    // R4 boundary: equal to cut dropped, one above kept
    sample(7, 1050, 1, "R4");
    sample(7, 1051, 1, "R4");
    // R3: upper container bits ignored
    sample(7, 16'hC000 | 1060, 1, "R3");
    // R3: baseline above sample clamps, below cut 0 -> no word
    sample(6, 100, 1, "R3");
    // R5: full scale on zero baseline saturates
    sample(5, 16383, 1, "R5");
    // R6: field placement with extreme channel and crossing
    xing_ctr = 8191;
    sample(127, base_m[127] + cut_m[127] + 77, 1, "R6");
    drain("R4");

    // random traffic, R8 ordering under back-pressure
    for (int i = 0; i < 600; i++) begin
      out_ready = ($urandom % 4) != 0;
      if ($urandom % 2) begin
        int ch = $urandom % 128;
        int s = base_m[ch] + int'($urandom % 120) - 40;
        if (s < 0) s = 0;
        s = s | (($urandom % 4) << 14);
        sample(ch, s, 1, "R8");
      end else begin
        in_chan = 7'($urandom); in_sample = 16'($urandom); // R11 junk with valid low
        step("R11");
      end
    end
    drain("R8");
    check(!ovf_flag && drop_count == 0, "R9", {ovf_flag, drop_count}, 32'h0);

    // R7: forward-all emits every sample, including clamped ones
    cfg(2, 0, 1);
    sample(6, 100, 1, "R7");
    for (int i = 0; i < 30; i++) sample($urandom % 128, $urandom % 16384, 1, "R7");
    for (int i = 0; i < 10; i++) begin
      in_sample = 16'($urandom); in_chan = 7'($urandom);
      step("R11");
    end
    drain("R7");

    // R9/R10: stall sink, overfill by 5
    out_ready = 0;
    for (int i = 0; i < DEPTH + 5; i++) sample($urandom % 128, $urandom % 16384, i < DEPTH, "R9");
    repeat (4) step("R9");
    check(out_valid && out_data == expq[0], "R8", out_data, expq[0]);
    check(ovf_flag == 1, "R9", {31'h0, ovf_flag}, 32'h1);
    check(drop_count == 5, "R9", {16'h0, drop_count}, 32'd5);
    stat_rd = 1; step("R10"); stat_rd = 0;
    #1;
    check(!ovf_flag && drop_count == 0, "R10", {ovf_flag, drop_count}, 32'h0);
    @(negedge clk);
    drain("R9");
    cfg(2, 0, 0);
    sample(7, 1050, 1, "R4");
    drain("R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule